// File: doc/BRIEF.md
# Port Pin-Function Select Register

This block is a small control register. It decides, for each upper pin of an 8-bit general-purpose port, whether the pin stays general-purpose I/O or carries an external bus-control function: data-enable, instruction-queue status, the E clock, the low-byte strobe or read/write. The chip operating mode arrives on two inputs. One is a normal/special flag. The other is a kind code for single-chip, expanded narrow, expanded wide or peripheral. The mode sets the value the register takes at reset, which writes it accepts, and which stored bits actually reach the pin multiplexer.

The CPU reaches the register through a single-cycle write strobe and a combinational read-data bus. Write protection runs in opposite directions in the two mode families. In normal modes only the first write after reset is taken. In special modes the first write is thrown away and every later one lands. The per-pin select outputs are decoded from the stored bits and the live mode inputs. A bit that has no effect in the current mode is hidden from the pins, but it is kept in the register and still reads back.

Top module: `ppf_select_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register loads a value that depends on the mode. Special expanded (narrow or wide) loads 8'hAC. Normal expanded and special single-chip load 8'h80. Normal single-chip loads 8'h90. Mode encoding: `mode_spec`=1 means special. `mode_kind` is 0 for single-chip, 1 for expanded narrow, 2 for expanded wide and 3 for peripheral.
- R2: In normal modes, the first `reg_wr` after reset updates bits 7, 5, 3 and 2 from `reg_wdata`. Every later write leaves those bits unchanged.
- R3: In special modes, the first `reg_wr` after reset leaves bits 7, 5, 3 and 2 unchanged. Every later write updates them.
- R4: In expanded modes, bit 4 (no-external-clock) reads 0 and ignores writes, and `sel_pin[4]` is 1.
- R5: In normal single-chip mode, bit 4 accepts only the first write after reset. In special single-chip mode it accepts every write, the first one included.
- R6: In peripheral mode, `reg_rdata` reads 0, writes have no effect, and all of `sel_pin` is 0.
- R7: Bits 6, 1 and 0 of `reg_rdata` always read 0.
- R8: `sel_pin[7]` (data-enable function) is 1 exactly when the mode is expanded and bit 7 is 0.
- R9: `sel_pin[6]` and `sel_pin[5]` (queue-status outputs) are both 1 exactly when the mode is expanded and bit 5 is 1.
- R10: In single-chip modes, `sel_pin[4]` (E clock) is 1 exactly when bit 4 is 0 and either `vis_in` is 1 or `strb_sel_in` is 0.
- R11: `sel_pin[2]` (read/write) equals bit 2 in expanded modes. `sel_pin[3]` (low strobe) equals bit 3 in expanded modes other than normal expanded narrow. Both are 0 in every other mode. `sel_pin[1:0]` are always 0.
- R12: A bit masked from `sel_pin` by the mode keeps its stored value and reads back through `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the mode-dependent default |
| mode_spec | input | 1 | 1 = special mode, 0 = normal mode |
| mode_kind | input | 2 | 0 single-chip, 1 expanded narrow, 2 expanded wide, 3 peripheral |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| vis_in | input | 1 | Internal-visibility enable, used in the single-chip E-clock rule |
| strb_sel_in | input | 1 | Strobe-select input, used in the single-chip E-clock rule |
| sel_pin | output | 8 | Per-pin select, 1 = bus-control function, 0 = general-purpose I/O |

## Verification
A write flag that is set or cleared wrongly shows up at the very next access. In normal modes the second write would land and change `reg_rdata` one cycle later. In special modes the first write would land. A wrong reset value or a wrong mask in the decode is visible on `reg_rdata` or `sel_pin` in the first cycle after reset. For that reason the bench compares both buses in every cycle, across all eight mode combinations and all four visibility and strobe-select patterns.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

  localparam int REG_W  = 8;
  localparam int B_DEN  = 7;   // data-enable disable
  localparam int B_QHI  = 6;   // upper queue-status pin
  localparam int B_QST  = 5;   // queue-status enable
  localparam int B_NCLK = 4;   // no external clock
  localparam int B_LSTB = 3;   // low strobe enable
  localparam int B_RW   = 2;   // read/write enable

  localparam logic [REG_W-1:0] IMPL_MASK =
    REG_W'((1 << B_DEN) | (1 << B_QST) | (1 << B_NCLK) | (1 << B_LSTB) | (1 << B_RW));

  typedef enum logic [1:0] {
    K_SINGLE = 2'd0,
    K_NARROW = 2'd1,
    K_WIDE   = 2'd2,
    K_PERIPH = 2'd3
  } op_kind_e;

  function automatic logic f_expanded(op_kind_e k);
    return (k == K_NARROW) || (k == K_WIDE);
  endfunction

  function automatic logic [REG_W-1:0] f_reset_value(logic spec, op_kind_e k);
    logic [REG_W-1:0] v;
    v        = '0;
    v[B_DEN] = 1'b1;
    if (f_expanded(k)) begin
      if (spec) begin
        v[B_QST]  = 1'b1;
        v[B_LSTB] = 1'b1;
        v[B_RW]   = 1'b1;
      end
    end else if (!(spec && k == K_SINGLE)) begin
      v[B_NCLK] = 1'b1;
    end
    return v;
  endfunction

  // Whether a write access may change bit idx, given its written flag.
  function automatic logic f_accept(int idx, logic spec, op_kind_e k, logic flag);
    if (k == K_PERIPH || !IMPL_MASK[idx]) return 1'b0;
    if (idx == B_NCLK) begin
      if (f_expanded(k)) return 1'b0;
      if (spec)          return 1'b1;
      return !flag;
    end
    return spec ? flag : !flag;
  endfunction

  function automatic logic f_eclk_sel(op_kind_e k, logic nclk, logic vis, logic strb);
    if (f_expanded(k))  return 1'b1;
    if (k == K_SINGLE)  return !nclk && (vis || !strb);
    return 1'b0;
  endfunction

  function automatic logic [REG_W-1:0] f_pin_sel(logic [REG_W-1:0] q, logic spec,
                                                 op_kind_e k, logic vis, logic strb);
    logic [REG_W-1:0] s;
    logic ex;
    ex        = f_expanded(k);
    s         = '0;
    s[B_DEN]  = ex && !q[B_DEN];
    s[B_QHI]  = ex && q[B_QST];
    s[B_QST]  = ex && q[B_QST];
    s[B_NCLK] = f_eclk_sel(k, q[B_NCLK], vis, strb);
    s[B_LSTB] = ex && q[B_LSTB] && !(!spec && k == K_NARROW);
    s[B_RW]   = ex && q[B_RW];
    return s;
  endfunction

endpackage

// File: rtl/ppf_bit_store.sv
module ppf_bit_store
  import ppf_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spec,
  input  op_kind_e     kind,
  input  logic         wr_access,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] ONCE_BITS = IMPL_MASK & ~(W'(1) << B_NCLK);

  logic [W-1:0] rst_val;
  logic [W-1:0] wr_flag;
  logic [W-1:0] bit_take;

  assign rst_val = f_reset_value(spec, kind);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_take[i] = wr_access && f_accept(i, spec, kind, wr_flag[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q[i]       <= rst_val[i];
        wr_flag[i] <= 1'b0;
      end else begin
        if (bit_take[i])  q[i]       <= wdata[i];
        if (wr_access)    wr_flag[i] <= 1'b1;
      end
    end

    if (ONCE_BITS[i]) begin : g_once_chk
      // R2: normal mode, bit already written -> write is ignored
      a_r2_normal_once: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_access && !spec && wr_flag[i]) |=> $stable(q[i]));
      // R3: special mode, first write -> ignored
      a_r3_special_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_access && spec && !wr_flag[i]) |=> $stable(q[i]));
    end
  end

  // R4: no-clock bit held low in expanded modes
  a_r4_nclk_zero: assert property (@(posedge clk) disable iff (!rst_n)
    f_expanded(kind) |-> !q[B_NCLK]);

  // R6: peripheral mode leaves the stored value alone
  a_r6_periph_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_PERIPH && $past(rst_n)) |=> $stable(q));

endmodule

// File: rtl/ppf_pin_decode.sv
module ppf_pin_decode
  import ppf_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] q,
  input  logic         spec,
  input  op_kind_e     kind,
  input  logic         vis,
  input  logic         strb,
  output logic [W-1:0] sel
);

  assign sel = f_pin_sel(q, spec, kind, vis, strb);

  // R10/R4: expanded modes always route the E clock
  a_r4_eclk_expanded: assert property (@(posedge clk) disable iff (!rst_n)
    f_expanded(kind) |-> sel[B_NCLK]);

  // R11: low strobe only when its stored bit is set
  a_r11_lstrb_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    sel[B_LSTB] |-> q[B_LSTB]);

  // R9: both queue-status pins move together
  a_r9_qstat_pair: assert property (@(posedge clk) disable iff (!rst_n)
    sel[B_QHI] == sel[B_QST]);

endmodule

// File: rtl/ppf_select_reg.sv
module ppf_select_reg
  import ppf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_spec,
  input  logic [1:0] mode_kind,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       vis_in,
  input  logic       strb_sel_in,
  output logic [7:0] sel_pin
);

  op_kind_e         kind;
  logic             reg_open;
  logic             wr_access;
  logic [REG_W-1:0] stored;

  assign kind      = op_kind_e'(mode_kind);
  assign reg_open  = (kind != K_PERIPH);
  assign wr_access = reg_wr && reg_open;

  ppf_bit_store #(.W(REG_W)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .spec      (mode_spec),
    .kind      (kind),
    .wr_access (wr_access),
    .wdata     (reg_wdata),
    .q         (stored)
  );

  ppf_pin_decode #(.W(REG_W)) decode_i (
    .clk   (clk),
    .rst_n (rst_n),
    .q     (stored),
    .spec  (mode_spec),
    .kind  (kind),
    .vis   (vis_in),
    .strb  (strb_sel_in),
    .sel   (sel_pin)
  );

  assign reg_rdata = reg_open ? stored : '0;

  // R7: unimplemented bits never reach the read bus
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~IMPL_MASK) == '0);

  // R6: peripheral mode drives no bus-control function
  a_r6_periph_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_PERIPH) |-> (sel_pin == '0));

endmodule

// File: tb/ppf_select_reg_tb_top.sv
module ppf_select_reg_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_spec = 1'b0;
  logic [1:0] mode_kind = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       vis_in = 1'b0;
  logic       strb_sel_in = 1'b0;
  logic [7:0] sel_pin;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  // model state
  logic [7:0] mreg;
  bit         mwritten;

  always #2 clk = ~clk;

  ppf_select_reg dut_i (
    .clk(clk), .rst_n(rst_n), .mode_spec(mode_spec), .mode_kind(mode_kind),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vis_in(vis_in), .strb_sel_in(strb_sel_in), .sel_pin(sel_pin)
  );

  function automatic bit is_exp();
    return mode_kind == 2'd1 || mode_kind == 2'd2;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h spec=%0d kind=%0d",
               req, act, exp, mode_spec, mode_kind);
    end
  endtask

  task automatic model_reset();
    mwritten = 0;
    if (is_exp())                     mreg = mode_spec ? 8'hAC : 8'h80;
    else if (mode_kind == 2'd0)       mreg = mode_spec ? 8'h80 : 8'h90;
    else                              mreg = 8'h90;
  endtask

  task automatic model_write(logic [7:0] d);
    int once_bits[4] = '{7, 5, 3, 2};
    bit ok;
    if (mode_kind == 2'd3) return;
    ok = mode_spec ? mwritten : !mwritten;
    foreach (once_bits[j]) if (ok) mreg[once_bits[j]] = d[once_bits[j]];
    if (mode_kind == 2'd0 && (mode_spec || !mwritten)) mreg[4] = d[4];
    mwritten = 1;
  endtask

  task automatic compare(string tag);
    logic [7:0] exp_rd;
    bit periph, ex, ck;
    periph = (mode_kind == 2'd3);
    ex     = is_exp();
    exp_rd = periph ? 8'h00 : mreg;
    chk(periph ? "R6" : tag, reg_rdata & 8'hEF, exp_rd & 8'hEF);
    chk(ex ? "R4" : (periph ? "R6" : "R5"), {7'b0, reg_rdata[4]}, {7'b0, exp_rd[4]});
    chk("R7", reg_rdata & 8'h43, 8'h00);
    if (periph) begin
      chk("R6", sel_pin, 8'h00);
      return;
    end
    chk("R8", {7'b0, sel_pin[7]}, {7'b0, ex && !mreg[7]});
    chk("R9", {6'b0, sel_pin[6:5]}, (ex && mreg[5]) ? 8'h03 : 8'h00);
    ck = ex ? 1'b1 : (!mreg[4] && (vis_in || !strb_sel_in));
    chk(ex ? "R4" : "R10", {7'b0, sel_pin[4]}, {7'b0, ck});
    if (!mode_spec && mode_kind == 2'd1 && mreg[3])
      chk("R12", {reg_rdata[3], sel_pin[3]}, 8'h02);
    else
      chk("R11", {7'b0, sel_pin[3]}, {7'b0, ex && mreg[3]});
    chk("R11", {6'b0, sel_pin[2], sel_pin[1]}, {6'b0, ex && mreg[2], 1'b0});
    chk("R11", {7'b0, sel_pin[0]}, 8'h00);
  endtask

  task automatic step(bit wr, logic [7:0] d, string tag);
    reg_wr    = wr;
    reg_wdata = d;
    @(posedge clk);
    if (wr) model_write(d);
    @(negedge clk);
    reg_wr = 1'b0;
    compare(tag);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    string wtag;
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      rst_n     = 1'b0;
      mode_spec = m[2];
      mode_kind = m[1:0];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      compare("R1");
      for (int v = 0; v < 4; v++) begin
        vis_in      = v[0];
        strb_sel_in = v[1];
        step(0, 8'h00, "R1");
      end
      wtag = mode_spec ? "R3" : "R2";
      step(1, 8'hFF, wtag);
      step(0, 8'h00, wtag);
      step(1, 8'h00, wtag);
      step(1, 8'hA4, wtag);
      for (int v = 0; v < 4; v++) begin
        vis_in      = v[0];
        strb_sel_in = v[1];
        step(0, 8'h00, wtag);
      end
      step(1, 8'h10, wtag);
      for (int v = 0; v < 4; v++) begin
        vis_in      = v[0];
        strb_sel_in = v[1];
        step(0, 8'h00, wtag);
      end
    end
    finish_run();
  end

endmodule